// File: doc/BRIEF.md
# Authenticated Load Address Sequencer

This block runs one 64-bit register load whose base pointer must pass an authentication check before it is used. It takes a 32-bit instruction word with a single-cycle start strobe and decodes the target and base register numbers, a key-select bit, a writeback flag and a 10-bit signed offset. It then reads the base from a general register or from the stack pointer and hands it to an external authenticator with a zero modifier and the selected key.

When the authenticator accepts the pointer, the block does three things. It checks stack-pointer alignment when the stack pointer is the base. It adds the offset, scaled by eight, to the stripped pointer. It then issues one 64-bit read. The loaded data goes to the target register. In pre-indexed form the block also writes the new address back to the base.

The authenticator, the memory and the register file all sit outside the block. They are reached through request/acknowledge ports and one register write port. An illegal encoding, a rejected pointer or a misaligned stack pointer ends the sequence with a one-cycle fault pulse and a cause code. In that case no memory read is issued and no register is written.

Top module: `authld_seq`

## Requirements
- R1: A word whose fixed bits differ from the load pattern ends the sequence with a fault pulse of cause 1 and no authenticator request. The fixed pattern is bits 31:24 = 8'b1111_1000, bit 21 = 1 and bit 10 = 1.
- R2: The authenticator request carries the base value with a zero modifier. Its key select equals instruction bit 23 (0 for key A, 1 for key B). The request stays asserted, with a stable pointer, until the acknowledge arrives.
- R3: Base field bits 9:5 equal to 31 select the stack pointer as base. Any other value selects the general register of that number.
- R4: The read address is the authenticated pointer plus the 10-bit value {bit 22, bits 20:12}, sign-extended and multiplied by 8. This gives byte offsets from -4096 to 4088. The address stays stable while the read waits for its acknowledge.
- R5: The 64-bit data returned by memory is written to the register numbered by bits 4:0.
- R6: When bit 11 is 1, the read address is written back to the base: to the stack-pointer port for base 31, or otherwise to the general register through the register write port. This happens in the cycle after the data write, never together with it. When bit 11 is 0 the base is left alone.
- R7: When bit 11 is 1 and the base and target numbers are equal and not 31, only the loaded data is written and the base is not updated.
- R8: The read is flagged tag-checked when writeback is requested or the base is not the stack pointer.
- R9: A failure response from the authenticator ends the sequence with a fault pulse of cause 2. No memory read and no register write follow.
- R10: When the stack pointer is the base and the authenticated pointer is not 16-byte aligned, the sequence ends with a fault pulse of cause 3. No memory read is issued. A memory read only starts right after a successful authentication.
- R11: The done and fault outputs are single-cycle pulses and never occur together. While busy is low, no request or write is active. After reset the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, sampled while idle |
| insn | input | 32 | Instruction word, captured with start |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Pulse in the last write cycle of a completed load |
| fault_pulse | output | 1 | Pulse when the sequence aborts |
| fault_cause | output | 2 | Abort cause during fault_pulse: 1 encoding, 2 authentication, 3 alignment |
| rf_raddr | output | 5 | Register file read index (base field) |
| rf_rdata | input | 64 | Register file read data |
| sp_rdata | input | 64 | Current stack pointer |
| auth_req | output | 1 | Authentication request |
| auth_ptr | output | 64 | Pointer to authenticate |
| auth_key_b | output | 1 | Key select, 1 for key B |
| auth_mod | output | 64 | Modifier, always zero |
| auth_ack | input | 1 | Authentication response valid |
| auth_fail | input | 1 | Authentication rejected, valid with auth_ack |
| auth_result | input | 64 | Pointer with its code removed, valid with auth_ack |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 64 | Byte address of the read |
| mem_tagchk | output | 1 | Tag-checked access flag |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 5 | Register write index |
| rf_wdata | output | 64 | Register write data |
| sp_we | output | 1 | Stack pointer write enable |
| sp_wdata | output | 64 | Stack pointer write data |

## Verification
The bound checker watches, on every cycle, the handshake rules and the sequencing invariants. It checks that requests hold with stable payloads until acknowledged, that a memory read only starts right after a good authentication, and that a fault is never accompanied by a read or a write. It also checks that the data and base writes never coincide, and that done and fault stay single, exclusive pulses. Only the bench scenarios can show the values involved: the key choice, the stack-pointer versus register base, the scaled offset at both extremes, the tag-check flag, the writeback target, the suppressed overlap writeback and each fault cause. The bench predicts each of these from its own register, memory and authenticator models.

// File: rtl/authld_pkg.sv
package authld_pkg;

   localparam int REG_IDX_W = 5;
   localparam int INSN_W    = 32;
   localparam int OFF_RAW_W = 10;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'd0,
      FLT_UNDEF = 2'd1,
      FLT_AUTH  = 2'd2,
      FLT_ALIGN = 2'd3
   } flt_cause_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_AUTH,
      ST_MEM,
      ST_LDWR,
      ST_BWR,
      ST_FAULT
   } seq_state_e;

endpackage

// File: rtl/authld_decode.sv
module authld_decode
   import authld_pkg::*;
(
   input  logic [INSN_W-1:0]    insn,
   output logic [REG_IDX_W-1:0] rt,
   output logic [REG_IDX_W-1:0] rn,
   output logic                 key_b,
   output logic [OFF_RAW_W-1:0] off_raw,
   output logic                 legal,
   output logic                 sp_base,
   output logic                 wb_eff,
   output logic                 tagchk
);
   logic wb_req;
   logic overlap;

   assign rt      = insn[4:0];
   assign rn      = insn[9:5];
   assign wb_req  = insn[11];
   assign key_b   = insn[23];
   assign off_raw = {insn[22], insn[20:12]};

   assign legal   = (insn[31:24] == 8'b1111_1000) && insn[21] && insn[10];
   assign sp_base = (rn == {REG_IDX_W{1'b1}});
   assign overlap = (rn == rt) && !sp_base;
   assign wb_eff  = wb_req && !overlap;
   assign tagchk  = wb_req || !sp_base;
endmodule

// File: rtl/authld_agu.sv
module authld_agu #(
   parameter int XLEN       = 64,
   parameter int OFF_W      = 10,
   parameter int SCALE_LOG2 = 3,
   parameter int ALIGN_LOG2 = 4
) (
   input  logic [XLEN-1:0]  base_auth,
   input  logic [OFF_W-1:0] off_raw,
   input  logic             sp_base,
   output logic [XLEN-1:0]  eff_addr,
   output logic             misaligned
);
   localparam int EXT_W = XLEN - OFF_W - SCALE_LOG2;

   logic [XLEN-1:0] offset;

   generate
      if (SCALE_LOG2 > 0) begin : g_scaled
         assign offset = {{EXT_W{off_raw[OFF_W-1]}}, off_raw, {SCALE_LOG2{1'b0}}};
      end else begin : g_unscaled
         assign offset = {{EXT_W{off_raw[OFF_W-1]}}, off_raw};
      end

      if (ALIGN_LOG2 > 0) begin : g_align
         assign misaligned = sp_base && (|base_auth[ALIGN_LOG2-1:0]);
      end else begin : g_noalign
         assign misaligned = sp_base & 1'b0;
      end
   endgenerate

   assign eff_addr = base_auth + offset;
endmodule

// File: rtl/authld_ctrl.sv
module authld_ctrl
   import authld_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       legal,
   input  logic       wb_eff,
   input  logic       auth_ack,
   input  logic       auth_fail,
   input  logic       misaligned,
   input  logic       mem_ack,
   output logic       busy,
   output logic       cap_insn,
   output logic       cap_base,
   output logic       cap_eff,
   output logic       cap_data,
   output logic       auth_req,
   output logic       mem_req,
   output logic       ld_we,
   output logic       base_we,
   output logic       done,
   output logic       fault_pulse,
   output logic [1:0] fault_cause
);
   seq_state_e state_q;
   flt_cause_e cause_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cause_q <= FLT_NONE;
      end else begin
         case (state_q)
            ST_IDLE: if (start) state_q <= ST_READ;
            ST_READ: begin
               if (legal) begin
                  state_q <= ST_AUTH;
               end else begin
                  state_q <= ST_FAULT;
                  cause_q <= FLT_UNDEF;
               end
            end
            ST_AUTH: begin
               if (auth_ack) begin
                  if (auth_fail) begin
                     state_q <= ST_FAULT;
                     cause_q <= FLT_AUTH;
                  end else if (misaligned) begin
                     state_q <= ST_FAULT;
                     cause_q <= FLT_ALIGN;
                  end else begin
                     state_q <= ST_MEM;
                  end
               end
            end
            ST_MEM:  if (mem_ack) state_q <= ST_LDWR;
            ST_LDWR: state_q <= wb_eff ? ST_BWR : ST_IDLE;
            ST_BWR:  state_q <= ST_IDLE;
            ST_FAULT: begin
               state_q <= ST_IDLE;
               cause_q <= FLT_NONE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      busy        = (state_q != ST_IDLE);
      cap_insn    = (state_q == ST_IDLE) && start;
      cap_base    = (state_q == ST_READ);
      cap_eff     = (state_q == ST_AUTH) && auth_ack;
      cap_data    = (state_q == ST_MEM) && mem_ack;
      auth_req    = (state_q == ST_AUTH);
      mem_req     = (state_q == ST_MEM);
      ld_we       = (state_q == ST_LDWR);
      base_we     = (state_q == ST_BWR);
      done        = ((state_q == ST_LDWR) && !wb_eff) || (state_q == ST_BWR);
      fault_pulse = (state_q == ST_FAULT);
      fault_cause = fault_pulse ? cause_q : FLT_NONE;
   end
endmodule

// File: rtl/authld_seq.sv
module authld_seq
   import authld_pkg::*;
#(
   parameter int XLEN       = 64,
   parameter int SCALE_LOG2 = 3,
   parameter int ALIGN_LOG2 = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [INSN_W-1:0]    insn,
   output logic                 busy,
   output logic                 done,
   output logic                 fault_pulse,
   output logic [1:0]           fault_cause,
   output logic [REG_IDX_W-1:0] rf_raddr,
   input  logic [XLEN-1:0]      rf_rdata,
   input  logic [XLEN-1:0]      sp_rdata,
   output logic                 auth_req,
   output logic [XLEN-1:0]      auth_ptr,
   output logic                 auth_key_b,
   output logic [XLEN-1:0]      auth_mod,
   input  logic                 auth_ack,
   input  logic                 auth_fail,
   input  logic [XLEN-1:0]      auth_result,
   output logic                 mem_req,
   output logic [XLEN-1:0]      mem_addr,
   output logic                 mem_tagchk,
   input  logic                 mem_ack,
   input  logic [XLEN-1:0]      mem_rdata,
   output logic                 rf_we,
   output logic [REG_IDX_W-1:0] rf_waddr,
   output logic [XLEN-1:0]      rf_wdata,
   output logic                 sp_we,
   output logic [XLEN-1:0]      sp_wdata
);
   generate
      if (XLEN < OFF_RAW_W + SCALE_LOG2 + 1) begin : g_bad_xlen
         $error("authld_seq: XLEN too small for the scaled offset");
      end
      if (ALIGN_LOG2 < 0 || ALIGN_LOG2 >= XLEN) begin : g_bad_align
         $error("authld_seq: ALIGN_LOG2 out of range");
      end
      if (SCALE_LOG2 < 0) begin : g_bad_scale
         $error("authld_seq: SCALE_LOG2 must not be negative");
      end
   endgenerate

   logic [INSN_W-1:0]    insn_q;
   logic [XLEN-1:0]      base_q, eff_q, data_q;
   logic [REG_IDX_W-1:0] rt, rn;
   logic [OFF_RAW_W-1:0] off_raw;
   logic                 key_b, legal, sp_base, wb_eff, tagchk;
   logic [XLEN-1:0]      eff_addr;
   logic                 misaligned;
   logic cap_insn, cap_base, cap_eff, cap_data, ld_we, base_we;

   authld_decode u_dec (
      .insn    (insn_q),
      .rt      (rt),
      .rn      (rn),
      .key_b   (key_b),
      .off_raw (off_raw),
      .legal   (legal),
      .sp_base (sp_base),
      .wb_eff  (wb_eff),
      .tagchk  (tagchk)
   );

   authld_agu #(
      .XLEN       (XLEN),
      .OFF_W      (OFF_RAW_W),
      .SCALE_LOG2 (SCALE_LOG2),
      .ALIGN_LOG2 (ALIGN_LOG2)
   ) u_agu (
      .base_auth  (auth_result),
      .off_raw    (off_raw),
      .sp_base    (sp_base),
      .eff_addr   (eff_addr),
      .misaligned (misaligned)
   );

   authld_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .legal       (legal),
      .wb_eff      (wb_eff),
      .auth_ack    (auth_ack),
      .auth_fail   (auth_fail),
      .misaligned  (misaligned),
      .mem_ack     (mem_ack),
      .busy        (busy),
      .cap_insn    (cap_insn),
      .cap_base    (cap_base),
      .cap_eff     (cap_eff),
      .cap_data    (cap_data),
      .auth_req    (auth_req),
      .mem_req     (mem_req),
      .ld_we       (ld_we),
      .base_we     (base_we),
      .done        (done),
      .fault_pulse (fault_pulse),
      .fault_cause (fault_cause)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         insn_q <= '0;
         base_q <= '0;
         eff_q  <= '0;
         data_q <= '0;
      end else begin
         if (cap_insn) insn_q <= insn;
         if (cap_base) base_q <= sp_base ? sp_rdata : rf_rdata;
         if (cap_eff)  eff_q  <= eff_addr;
         if (cap_data) data_q <= mem_rdata;
      end
   end

   assign rf_raddr   = rn;
   assign auth_ptr   = base_q;
   assign auth_key_b = key_b;
   assign auth_mod   = '0;
   assign mem_addr   = eff_q;
   assign mem_tagchk = tagchk;
   assign rf_we      = ld_we || (base_we && !sp_base);
   assign rf_waddr   = ld_we ? rt : rn;
   assign rf_wdata   = ld_we ? data_q : eff_q;
   assign sp_we      = base_we && sp_base;
   assign sp_wdata   = eff_q;
endmodule

// File: rtl/authld_seq_chk.sv
module authld_seq_chk #(
   parameter int XLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            busy,
   input logic            done,
   input logic            fault_pulse,
   input logic            auth_req,
   input logic [XLEN-1:0] auth_ptr,
   input logic            auth_ack,
   input logic            mem_req,
   input logic [XLEN-1:0] mem_addr,
   input logic            mem_ack,
   input logic            rf_we,
   input logic            sp_we
);
   // R2
   auth_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      auth_req && !auth_ack |=> auth_req && $stable(auth_ptr));

   // R4
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

   // R10
   mem_after_auth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> $past(auth_req) && $past(auth_ack));

   // R9
   fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_pulse |-> !mem_req && !rf_we && !sp_we);

   // R6
   write_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rf_we && sp_we));

   // R11
   fault_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_pulse |=> !fault_pulse);

   // R11
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   done_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fault_pulse));

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !auth_req && !mem_req && !rf_we && !sp_we);
endmodule

bind authld_seq authld_seq_chk #(.XLEN(XLEN)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (busy),
   .done        (done),
   .fault_pulse (fault_pulse),
   .auth_req    (auth_req),
   .auth_ptr    (auth_ptr),
   .auth_ack    (auth_ack),
   .mem_req     (mem_req),
   .mem_addr    (mem_addr),
   .mem_ack     (mem_ack),
   .rf_we       (rf_we),
   .sp_we       (sp_we)
);

// File: tb/authld_seq_test.sv
module authld_seq_test;
   localparam int EV_AUTH = 0, EV_MEM = 1, EV_XW = 2, EV_SPW = 3, EV_FLT = 4;

   typedef struct {
      int          kind;
      logic [63:0] a;
      logic [63:0] b;
      string       req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] insn = '0;
   logic        busy, done, fault_pulse;
   logic [1:0]  fault_cause;
   logic [4:0]  rf_raddr, rf_waddr;
   logic [63:0] rf_rdata, sp_rdata, auth_ptr, auth_mod, mem_addr, rf_wdata, sp_wdata;
   logic        auth_req, auth_key_b, mem_req, mem_tagchk, rf_we, sp_we;
   logic        auth_ack = 1'b0, auth_fail = 1'b0, mem_ack = 1'b0;
   logic [63:0] auth_result = '0, mem_rdata = '0;

   logic [63:0] regs [32];
   logic [63:0] sp_q;
   exp_t        sb[$];
   int          checks = 0, errors = 0;
   bit          op_end = 0;

   always #10 clk = ~clk;

   authld_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .insn(insn),
      .busy(busy), .done(done), .fault_pulse(fault_pulse), .fault_cause(fault_cause),
      .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .sp_rdata(sp_rdata),
      .auth_req(auth_req), .auth_ptr(auth_ptr), .auth_key_b(auth_key_b), .auth_mod(auth_mod),
      .auth_ack(auth_ack), .auth_fail(auth_fail), .auth_result(auth_result),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_tagchk(mem_tagchk),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
      .sp_we(sp_we), .sp_wdata(sp_wdata)
   );

   assign rf_rdata = regs[rf_raddr];
   assign sp_rdata = sp_q;

   function automatic bit tag_ok(logic [63:0] p, logic kb);
      return p[63:56] == (kb ? 8'hB5 : 8'hA5);
   endfunction

   function automatic logic [63:0] mem_model(logic [63:0] addr);
      return addr ^ 64'h5A5A_0000_1234_0000;
   endfunction

   function automatic logic [31:0] enc(logic m, logic s, logic [8:0] imm, logic w,
                                       logic [4:0] rn, logic [4:0] rt);
      return {8'b1111_1000, m, s, 1'b1, imm, w, 1'b1, rn, rt};
   endfunction

   task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   // external authenticator, memory and register file models
   always @(negedge clk) begin
      auth_ack    <= auth_req && !auth_ack;
      auth_fail   <= !tag_ok(auth_ptr, auth_key_b);
      auth_result <= {8'h00, auth_ptr[55:0]};
      mem_ack     <= mem_req && !mem_ack;
      mem_rdata   <= mem_model(mem_addr);
      if (rf_we && rf_waddr != 5'd31) regs[rf_waddr] <= rf_wdata;
      if (sp_we) sp_q <= sp_wdata;
   end

   // monitor: pops expected events in order
   task automatic observe(int kind, logic [63:0] a, logic [63:0] b);
      exp_t e;
      if (sb.size() == 0) begin
         check(0, "R11", $sformatf("unexpected event kind %0d", kind), a, 64'h0);
      end else begin
         e = sb.pop_front();
         check(e.kind == kind, e.req, "event kind", 64'(kind), 64'(e.kind));
         check(e.a === a, e.req, $sformatf("event %0d first field", kind), a, e.a);
         check(e.b === b, e.req, $sformatf("event %0d second field", kind), b, e.b);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (auth_req && !auth_ack) observe(EV_AUTH, auth_ptr, {auth_mod[62:0], auth_key_b});
         if (mem_req && !mem_ack)   observe(EV_MEM, mem_addr, {63'h0, mem_tagchk});
         if (rf_we)                 observe(EV_XW, {59'h0, rf_waddr}, rf_wdata);
         if (sp_we)                 observe(EV_SPW, 64'h0, sp_wdata);
         if (fault_pulse)           observe(EV_FLT, {62'h0, fault_cause}, 64'h0);
         if (done || fault_pulse) op_end = 1;
      end
   end

   function automatic exp_t mk(int k, logic [63:0] a, logic [63:0] b, string r);
      exp_t e;
      e.kind = k; e.a = a; e.b = b; e.req = r;
      return e;
   endfunction

   // driver: predicts events, pushes them, runs the instruction
   task automatic run(logic [31:0] w, string req);
      logic [4:0]  rt = w[4:0], rn = w[9:5];
      logic        kb = w[23], wb = w[11];
      logic [63:0] base, auth, eff, off;
      bit          legal = (w[31:24] == 8'b1111_1000) && w[21] && w[10];
      base = (rn == 5'd31) ? sp_q : regs[rn];
      off  = {{51{w[22]}}, w[22], w[20:12], 3'b000};
      if (!legal) begin
         sb.push_back(mk(EV_FLT, 64'd1, 64'h0, {req, "/R1"}));
      end else begin
         sb.push_back(mk(EV_AUTH, base, {63'h0, kb}, {req, "/R2/R3"}));
         auth = {8'h00, base[55:0]};
         if (!tag_ok(base, kb)) begin
            sb.push_back(mk(EV_FLT, 64'd2, 64'h0, {req, "/R9"}));
         end else if (rn == 5'd31 && auth[3:0] != 4'h0) begin
            sb.push_back(mk(EV_FLT, 64'd3, 64'h0, {req, "/R10"}));
         end else begin
            eff = auth + off;
            sb.push_back(mk(EV_MEM, eff, {63'h0, wb || rn != 5'd31}, {req, "/R4/R8"}));
            sb.push_back(mk(EV_XW, {59'h0, rt}, mem_model(eff), {req, "/R5"}));
            if (wb && !(rn == rt && rn != 5'd31)) begin
               if (rn == 5'd31) sb.push_back(mk(EV_SPW, 64'h0, eff, {req, "/R6"}));
               else sb.push_back(mk(EV_XW, {59'h0, rn}, eff, {req, "/R6"}));
            end
         end
      end
      @(negedge clk);
      op_end = 0;
      insn   = w;
      start  = 1'b1;
      @(negedge clk);
      start  = 1'b0;
      for (int i = 0; i < 60 && !op_end; i++) @(negedge clk);
      check(op_end, req, "sequence end seen", 64'(op_end), 64'd1);
      repeat (2) @(negedge clk);
      check(sb.size() == 0, req, "all predicted events consumed", 64'(sb.size()), 64'd0);
      sb.delete();
      check(!busy, "R11", "idle after sequence", 64'(busy), 64'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 32; i++) regs[i] = {8'hA5, 56'(i) << 12};
      regs[6] = {8'hB5, 56'h0000_0000_0600_0000};
      regs[8] = {8'hB5, 56'h0000_0000_0800_0000};
      sp_q    = {8'hA5, 56'h0000_0000_0000_7FF0};
      repeat (3) @(negedge clk);
      // R11 reset state
      check(!busy && !auth_req && !mem_req && !rf_we && !sp_we && !fault_pulse && !done,
            "R11", "reset outputs quiet", {58'h0, busy, auth_req, mem_req, rf_we, sp_we, fault_pulse}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);

      run(enc(1'b0, 1'b0, 9'd5,   1'b0, 5'd3,  5'd4),  "R2 keyA offset");
      run(enc(1'b1, 1'b1, 9'd0,   1'b0, 5'd6,  5'd7),  "R4 keyB min offset");
      run(enc(1'b1, 1'b0, 9'd511, 1'b0, 5'd8,  5'd10), "R4 max offset");
      run(enc(1'b0, 1'b0, 9'd2,   1'b0, 5'd31, 5'd11), "R3 sp base untagged");
      run(enc(1'b0, 1'b1, 9'h1FE, 1'b1, 5'd12, 5'd13), "R6 pre-index xreg");
      run(enc(1'b0, 1'b0, 9'd4,   1'b1, 5'd14, 5'd14), "R7 overlap suppressed");
      run(enc(1'b0, 1'b1, 9'h1FC, 1'b1, 5'd31, 5'd15), "R6 pre-index sp");
      run(enc(1'b0, 1'b0, 9'd1,   1'b0, 5'd17, 5'd17), "R7 offset form overlap");
      run(enc(1'b0, 1'b0, 9'd1,   1'b0, 5'd6,  5'd18), "R9 wrong key A");
      run(enc(1'b1, 1'b0, 9'd1,   1'b0, 5'd19, 5'd20), "R9 wrong key B");
      run(enc(1'b0, 1'b0, 9'd0,   1'b0, 5'd12, 5'd21), "R9 stripped pointer");
      sp_q = {8'hA5, 56'h0000_0000_0000_9008};
      run(enc(1'b0, 1'b0, 9'd1,   1'b0, 5'd31, 5'd22), "R10 sp misaligned");
      check(regs[22] == {8'hA5, 56'(22) << 12}, "R10", "target untouched",
            regs[22], {8'hA5, 56'(22) << 12});
      sp_q = {8'hA5, 56'h0000_0000_0000_9000};
      run(enc(1'b0, 1'b0, 9'd3,   1'b1, 5'd31, 5'd31), "R8 sp base writeback");
      run(enc(1'b0, 1'b0, 9'd1,   1'b0, 5'd2,  5'd23) | 32'h0400_0000, "R1 bad bit 26");
      run(enc(1'b0, 1'b0, 9'd1,   1'b0, 5'd2,  5'd23) & ~32'h0000_0400, "R1 bad bit 10");
      run(enc(1'b0, 1'b0, 9'd7,   1'b0, 5'd2,  5'd24), "R5 recovery after faults");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule